// File: doc/BRIEF.md
# Dual-Channel Digital Downconverter

This block brings two real intermediate-frequency sample streams down to complex baseband. On every clock cycle it takes one signed 16-bit sample per channel. A shared oscillator supplies the cosine and negated sine of a tone at exactly one fifth of the sample rate, so a five-step table covers a full period. Each channel forms in-phase and quadrature products from these values. A boxcar accumulator then sums a block of products, scales the sum, rounds it and saturates it to 16 bits.

One mode input selects the decimation factor. Wide mode sums 10 samples per output and narrow mode sums 20. A new mode is taken up only where one output block ends and the next begins. Both channels share the block timing, so one strobe marks fresh I and Q words on every channel at once.

Top module: `ddc_dual`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next cycle shows `out_valid` low and all of `i_out` and `q_out` at zero.
- R2: The oscillator index starts at 0 for the first sample after reset and steps 0,1,2,3,4,0,... once per sample. Cosine by index is 32767, 10126, -26509, -26509, 10126. Negated sine by index is 0, -31163, -19260, 19260, 31163.
- R3: Each channel's I product is sample times cosine, and its Q product is sample times negated sine, both at full precision.
- R4: Each output is the sum of its block's products plus 2^(SH-1), arithmetically shifted right by SH bits (round half up). SH is 17 in wide mode and 18 in narrow mode.
- R5: `bw_narrow`=0 selects blocks of 10 samples and `bw_narrow`=1 selects blocks of 20. `out_valid` is a one-cycle pulse, once per block.
- R6: Each block's length is set by `bw_narrow` as sampled with the block's first sample. A change in the middle of a block has no effect on that block. Every block starts its sum from zero.
- R7: Rounded results above 32767 give 32767, and results below -32768 give -32768.
- R8: Channel c uses bits [16c+15:16c] of each bus. Channels do not affect one another, and one `out_valid` covers all I and Q words.
- R9: Counting the first sample after reset as sample 0, the block ending at sample n raises `out_valid` right after rising edge n+1. Outputs hold between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; one sample per channel per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| bw_narrow | input | 1 | 0 = 10-sample blocks, 1 = 20-sample blocks |
| samp_in | input | 32 | Signed samples, channel c at bits [16c+15:16c] |
| i_out | output | 32 | Rounded in-phase results, channel c at bits [16c+15:16c] |
| q_out | output | 32 | Rounded quadrature results, same packing |
| out_valid | output | 1 | One-cycle strobe marking new results |

## Verification
The assertions watch properties that hold on every cycle. The oscillator index wraps after 4 and otherwise steps by one, and the strobe never lasts two cycles. The block counter stays in range and the mode holds between block boundaries. The accumulators are empty after each boundary, and a zero sample gives zero products. The outputs hold between strobes and reset clears them. The bench scenarios are needed to show the numerical results, namely the rounding and saturation values, the tone and sign patterns and the independence of the channels. They also show where a mid-block mode change takes effect and when the strobe occurs relative to the samples.

// File: rtl/ddc_pkg.sv
// Shared constants and oscillator table for the dual downconverter.
// Assumes the tone sits at exactly one fifth of the sample rate.
package ddc_pkg;
    localparam int COEF_W  = 16;
    localparam int NCO_LEN = 5;
    localparam int PH_W    = $clog2(NCO_LEN);

    // Cosine of index*72 degrees, Q1.15.
    function automatic logic signed [COEF_W-1:0] nco_cos(input logic [PH_W-1:0] ph);
        case (ph)
            3'd0:       return 16'sd32767;
            3'd1, 3'd4: return 16'sd10126;
            3'd2, 3'd3: return -16'sd26509;
            default:    return '0;
        endcase
    endfunction

    // Negated sine of index*72 degrees, Q1.15.
    function automatic logic signed [COEF_W-1:0] nco_nsin(input logic [PH_W-1:0] ph);
        case (ph)
            3'd1:    return -16'sd31163;
            3'd2:    return -16'sd19260;
            3'd3:    return 16'sd19260;
            3'd4:    return 16'sd31163;
            default: return '0;
        endcase
    endfunction
endpackage

// File: rtl/ddc_nco.sv
// Five-step oscillator shared by all channels. It provides the cosine and
// negated sine for the sample presented this cycle. The index restarts at zero
// in reset and advances once per clock, since every clock carries a sample.
module ddc_nco
    import ddc_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    output logic signed [COEF_W-1:0] cos_o,
    output logic signed [COEF_W-1:0] nsin_o
);
    localparam logic [PH_W-1:0] LAST = PH_W'(NCO_LEN - 1);

    logic [PH_W-1:0] phase;

    // Advance the table index and wrap after the last entry.
    always_ff @(posedge clk) begin
        if (!rst_n)              phase <= '0;
        else if (phase == LAST)  phase <= '0;
        else                     phase <= phase + 1'b1;
    end

    // Table lookup for the current index.
    always_comb begin
        cos_o  = nco_cos(phase);
        nsin_o = nco_nsin(phase);
    end

    a_r2_phase_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == LAST) |=> (phase == '0));
    a_r2_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != LAST) |=> (phase == $past(phase) + 1'b1));
endmodule

// File: rtl/ddc_ctrl.sv
// Block timing shared by all channels. It marks when a product is valid,
// counts products in the current block, latches the mode at each block
// boundary and produces the output strobe one cycle after the block closes.
module ddc_ctrl #(
    parameter int DEC_WIDE   = 10,
    parameter int DEC_NARROW = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bw_narrow,
    output logic pvld,
    output logic dump,
    output logic narrow,
    output logic out_valid
);
    localparam int CNT_W = $clog2(DEC_NARROW);
    localparam logic [CNT_W-1:0] LAST_W = CNT_W'(DEC_WIDE - 1);
    localparam logic [CNT_W-1:0] LAST_N = CNT_W'(DEC_NARROW - 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;

    // Last count of the block in progress.
    always_comb last = narrow ? LAST_N : LAST_W;

    // The block closes on the product of its final sample.
    always_comb dump = pvld && (cnt == last);

    // Products become valid one edge after reset is released.
    always_ff @(posedge clk) begin
        if (!rst_n) pvld <= 1'b0;
        else        pvld <= 1'b1;
    end

    // Count products and restart at each block boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= '0;
        else if (dump)  cnt <= '0;
        else if (pvld)  cnt <= cnt + 1'b1;
    end

    // Take the mode as seen with the first sample of the next block.
    always_ff @(posedge clk) begin
        if (!rst_n)     narrow <= bw_narrow;
        else if (dump)  narrow <= bw_narrow;
    end

    // Strobe for the results written on the closing edge.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= dump;
    end

    a_r5_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);
    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pvld |-> (cnt <= last));
    a_r6_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !dump |=> $stable(narrow));
endmodule

// File: rtl/ddc_mixer.sv
// One channel's mixer. It registers the full-precision products of the sample
// with the cosine and negated sine values. Assumes signed inputs.
module ddc_mixer
    import ddc_pkg::*;
#(
    parameter int IN_W = 16,
    localparam int PR_W = IN_W + COEF_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [IN_W-1:0]   samp,
    input  logic signed [COEF_W-1:0] cos_i,
    input  logic signed [COEF_W-1:0] nsin_i,
    output logic signed [PR_W-1:0]   prod_i,
    output logic signed [PR_W-1:0]   prod_q
);
    // Capture both products of the current sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_i <= '0;
            prod_q <= '0;
        end else begin
            prod_i <= PR_W'(samp * cos_i);
            prod_q <= PR_W'(samp * nsin_i);
        end
    end

    a_r3_zero_in: assert property (@(posedge clk) disable iff (!rst_n)
        (samp == '0) |=> (prod_i == '0 && prod_q == '0));
endmodule

// File: rtl/ddc_decim.sv
// One channel's boxcar decimator for I and Q. It sums the products over a
// block. On the closing product it writes the rounded, saturated result and
// empties the sums. The shift depends on the mode, which holds the block gain
// near 1.25 for a tone at the oscillator frequency.
module ddc_decim #(
    parameter int PR_W       = 32,
    parameter int OUT_W      = 16,
    parameter int COEF_W     = 16,
    parameter int DEC_WIDE   = 10,
    parameter int DEC_NARROW = 20
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pvld,
    input  logic                    dump,
    input  logic                    narrow,
    input  logic signed [PR_W-1:0]  prod_i,
    input  logic signed [PR_W-1:0]  prod_q,
    output logic signed [OUT_W-1:0] i_out,
    output logic signed [OUT_W-1:0] q_out
);
    localparam int ACC_W = PR_W + $clog2(DEC_NARROW);
    localparam int SH_W  = COEF_W - 2 + $clog2(DEC_WIDE) - 1;
    localparam int SH_N  = COEF_W - 2 + $clog2(DEC_NARROW) - 1;
    localparam logic signed [ACC_W:0] RND_W = {{ACC_W{1'b0}}, 1'b1} << (SH_W - 1);
    localparam logic signed [ACC_W:0] RND_N = {{ACC_W{1'b0}}, 1'b1} << (SH_N - 1);
    localparam logic signed [ACC_W:0] MAXV  =
        $signed({{(ACC_W - OUT_W + 2){1'b0}}, {(OUT_W - 1){1'b1}}});
    localparam logic signed [ACC_W:0] MINV  = -MAXV - 1;

    logic signed [ACC_W-1:0] acc_i, acc_q;
    logic signed [ACC_W-1:0] sum_i, sum_q;

    // Round half up by the mode's shift, then clamp to the output range.
    function automatic logic signed [OUT_W-1:0] rnd_sat(input logic signed [ACC_W-1:0] v,
                                                        input logic nar);
        logic signed [ACC_W:0] t;
        logic signed [ACC_W:0] s;
        t = {v[ACC_W-1], v} + (nar ? RND_N : RND_W);
        s = nar ? (t >>> SH_N) : (t >>> SH_W);
        if (s > MAXV)      s = MAXV;
        else if (s < MINV) s = MINV;
        return s[OUT_W-1:0];
    endfunction

    // Running sums including this cycle's products.
    always_comb begin
        sum_i = acc_i + ACC_W'(prod_i);
        sum_q = acc_q + ACC_W'(prod_q);
    end

    // Accumulate, or close the block and write the scaled results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_i <= '0;
            acc_q <= '0;
            i_out <= '0;
            q_out <= '0;
        end else if (dump) begin
            acc_i <= '0;
            acc_q <= '0;
            i_out <= rnd_sat(sum_i, narrow);
            q_out <= rnd_sat(sum_q, narrow);
        end else if (pvld) begin
            acc_i <= sum_i;
            acc_q <= sum_q;
        end
    end

    a_r6_acc_clear: assert property (@(posedge clk) disable iff (!rst_n)
        dump |=> (acc_i == '0 && acc_q == '0));
    a_r9_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !dump |=> ($stable(i_out) && $stable(q_out)));
endmodule

// File: rtl/ddc_dual.sv
// Top of the multi-channel downconverter. It holds one oscillator and one
// block controller shared by all channels, plus a mixer and decimator per
// channel. Channels are packed into flat buses, channel c in slice c.
module ddc_dual #(
    parameter int NCH        = 2,
    parameter int IN_W       = 16,
    parameter int OUT_W      = 16,
    parameter int DEC_WIDE   = 10,
    parameter int DEC_NARROW = 20
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bw_narrow,
    input  logic [NCH*IN_W-1:0]    samp_in,
    output logic [NCH*OUT_W-1:0]   i_out,
    output logic [NCH*OUT_W-1:0]   q_out,
    output logic                   out_valid
);
    localparam int CW   = ddc_pkg::COEF_W;
    localparam int PR_W = IN_W + CW;

    logic signed [CW-1:0] cos_v, nsin_v;
    logic pvld, dump, narrow;

    ddc_nco u_nco (
        .clk    (clk),
        .rst_n  (rst_n),
        .cos_o  (cos_v),
        .nsin_o (nsin_v)
    );

    ddc_ctrl #(.DEC_WIDE(DEC_WIDE), .DEC_NARROW(DEC_NARROW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bw_narrow (bw_narrow),
        .pvld      (pvld),
        .dump      (dump),
        .narrow    (narrow),
        .out_valid (out_valid)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic signed [PR_W-1:0]  p_i, p_q;
        logic signed [OUT_W-1:0] r_i, r_q;

        ddc_mixer #(.IN_W(IN_W)) u_mix (
            .clk    (clk),
            .rst_n  (rst_n),
            .samp   ($signed(samp_in[c*IN_W +: IN_W])),
            .cos_i  (cos_v),
            .nsin_i (nsin_v),
            .prod_i (p_i),
            .prod_q (p_q)
        );

        ddc_decim #(
            .PR_W(PR_W), .OUT_W(OUT_W), .COEF_W(CW),
            .DEC_WIDE(DEC_WIDE), .DEC_NARROW(DEC_NARROW)
        ) u_dec (
            .clk    (clk),
            .rst_n  (rst_n),
            .pvld   (pvld),
            .dump   (dump),
            .narrow (narrow),
            .prod_i (p_i),
            .prod_q (p_q),
            .i_out  (r_i),
            .q_out  (r_q)
        );

        assign i_out[c*OUT_W +: OUT_W] = r_i;
        assign q_out[c*OUT_W +: OUT_W] = r_q;
    end

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && i_out == '0 && q_out == '0));
endmodule

// File: tb/tb_ddc_dual.sv
// Bench: a scenario table walked by one loop, then directed cases for
// mid-block mode changes and reset in the middle of a block.
module tb_ddc_dual;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bw_narrow = 1'b0;
    logic [31:0] samp_in = '0;
    logic [31:0] i_out, q_out;
    logic        out_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    ddc_dual dut (
        .clk(clk), .rst_n(rst_n), .bw_narrow(bw_narrow),
        .samp_in(samp_in), .i_out(i_out), .q_out(q_out), .out_valid(out_valid)
    );

    // pat0, amp0, pat1, amp1, bw, I0, Q0, I1, Q1.
    // Patterns: 0 zero, 1 constant, 2 sign of cosine, 3 sign of negated sine.
    localparam int NROW = 6;
    localparam int TBL [NROW][9] = '{
        '{0,     0, 0,      0, 0,     0,     0,      0,    0},  // R4 zero in
        '{2,  8000, 2,  -8000, 0, 12944,     0, -12944,    0},  // R4 R5 wide
        '{2,  8000, 2,  -8000, 1, 12944,     0, -12944,    0},  // R4 R5 narrow
        '{2, 32767, 2, -32767, 0, 32767,     0, -32768,    0},  // R7 clamp
        '{2,  8000, 1,   1000, 1, 12944,     0,      0,    0},  // R8 independent
        '{3,  8000, 3,   4000, 0,     0, 12310,      0, 6155}   // R3 quadrature
    };

    function automatic int samp_val(input int pat, input int amp, input int ph);
        case (pat)
            1:       return amp;
            2:       return (ph == 2 || ph == 3) ? -amp : amp;
            3:       return (ph == 0) ? 0 : ((ph == 1 || ph == 2) ? -amp : amp);
            default: return 0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string rq, input int got, input int exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s got %0d expected %0d", rq, got, exp_v);
        end
    endtask

    // Reset, then drive nsamp samples and check every cycle. The mode is
    // bw_a before sample sw1, bw_b from sw1 up to sw2, then bw_a again.
    task automatic run(input int p0, input int a0, input int p1, input int a1,
                       input int bw_a, input int bw_b, input int sw1, input int sw2,
                       input int nsamp, input int e[4], input bit chk_vals);
        bit exp_at [0:255];
        int next_start;
        int held [4];
        foreach (exp_at[k]) exp_at[k] = 1'b0;
        foreach (held[k]) held[k] = 0;
        next_start = 0;
        @(negedge clk);
        rst_n = 1'b0;
        bw_narrow = bw_a[0];
        samp_in = 32'h1234_5678;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1 valid in reset", int'(out_valid), 0);
        chk(i_out == '0 && q_out == '0, "R1 outputs in reset", int'(i_out), 0);
        for (int j = 0; j <= nsamp; j++) begin
            int bwj;
            int ph;
            if (j > 0) begin
                int ed;
                int got [4];
                @(negedge clk);
                ed = j - 1;
                got[0] = int'($signed(i_out[15:0]));
                got[1] = int'($signed(q_out[15:0]));
                got[2] = int'($signed(i_out[31:16]));
                got[3] = int'($signed(q_out[31:16]));
                chk(out_valid == exp_at[ed], "R5 R6 R9 strobe timing",
                    int'(out_valid), int'(exp_at[ed]));
                if (out_valid && exp_at[ed]) begin
                    if (chk_vals)
                        for (int k = 0; k < 4; k++)
                            chk(got[k] == e[k], "R4 R7 R8 result", got[k], e[k]);
                    for (int k = 0; k < 4; k++) held[k] = got[k];
                end else if (!out_valid) begin
                    for (int k = 0; k < 4; k++)
                        chk(got[k] == held[k], "R9 hold between strobes", got[k], held[k]);
                end
            end
            rst_n = 1'b1;
            bwj = (j < sw1) ? bw_a : ((j < sw2) ? bw_b : bw_a);
            bw_narrow = bwj[0];
            if (j == next_start) begin
                next_start = j + (bwj != 0 ? 20 : 10);
                if (next_start < 256) exp_at[next_start] = 1'b1;
            end
            ph = j % 5;  // R2: index restarts at zero after reset
            samp_in[15:0]  = 16'(samp_val(p0, a0, ph));
            samp_in[31:16] = 16'(samp_val(p1, a1, ph));
        end
    endtask

    initial begin
        int e [4];
        // Table walk; each run ends off a multiple of 5, so the next run
        // shows the R2 restart of the oscillator index.
        for (int r = 0; r < NROW; r++) begin
            int d;
            d = (TBL[r][4] != 0) ? 20 : 10;
            for (int k = 0; k < 4; k++) e[k] = TBL[r][5 + k];
            run(TBL[r][0], TBL[r][1], TBL[r][2], TBL[r][3],
                TBL[r][4], TBL[r][4], 1000, 1000, 3 * d + 2, e, 1'b1);
        end
        // R6: mode flips in the middle of blocks and is taken at boundaries.
        e = '{12944, 0, -12944, 0};
        run(2, 8000, 2, -8000, 0, 1, 5, 30, 52, e, 1'b1);
        // R6: narrow start, wide request inside the first block.
        run(2, 8000, 2, -8000, 1, 0, 3, 25, 62, e, 1'b1);
        // R1: reset cut into a block, then a clean restart (results unchecked
        // for the interrupted part; strobes and reset state are checked).
        run(1, 500, 1, -500, 0, 0, 1000, 1000, 7, e, 1'b0);
        e = '{32767, 0, -32768, 0};
        run(2, 32767, 2, -32767, 1, 1, 1000, 1000, 42, e, 1'b1);  // R7 narrow
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired got 1 expected 0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule